// File: doc/BRIEF.md
# Banked Flash Cartridge Address Mapper

This block lets an 8-bit CPU with a 16-bit address bus reach a 2 MB parallel flash through a 32 KB cartridge window at 0x8000–0xFFFF. Address bit 15 enables the flash. Address bit 14 splits the window into two halves. The lower 16 KB half is a switchable bank: its upper flash address bits come from a bank register. The upper 16 KB half is fixed on the last bank of the flash. The interrupt vectors and any code kept in the top 16 KB therefore stay in place while the bank changes.

The bank number is 7 bits wide, which gives 128 banks of 16 KB. It is loaded serially. Each shift strobe pushes one bit into a shadow register, most significant bit first. A separate latch strobe then copies the shadow into the active bank register. The mapping changes only on that latch, so a half-finished load never moves the switchable window. The CPU address path through the block is combinational. The shadow and active registers use a synchronous active-high reset.

Top module: `cart_mapper`

## Requirements
- R1: `flash_ce_n` is 0 when `cpu_addr[15]` is 1, and 1 when `cpu_addr[15]` is 0, in the same cycle.
- R2: When `cpu_addr[14]` is 0, `flash_addr[20:14]` equals the active bank and `flash_addr[13:0]` equals `cpu_addr[13:0]`.
- R3: When `cpu_addr[14]` is 1, `flash_addr[20:14]` is 7'h7F whatever the bank, and `flash_addr[13:0]` equals `cpu_addr[13:0]`. In particular, 0xFFFA–0xFFFF always map to flash 0x1FFFFA–0x1FFFFF.
- R4: Each clock with `ser_shift` high shifts `ser_bit` into the shadow register at bit 0 and moves the older bits up. After seven shifts, the first bit sent is the bank MSB.
- R5: Shift strobes without a latch strobe leave the mapping unchanged.
- R6: A clock with `bank_latch` high copies the shadow register into the active bank. The new mapping shows on `flash_addr` right after that clock edge.
- R7: Reset clears both the active bank and the shadow register to 0.
- R8: When more than seven bits are shifted in, only the last seven are kept.
- R9: When `ser_shift` and `bank_latch` are high in the same clock, the latch takes the shadow value from before that clock's shift, and the shift still takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address bus |
| ser_bit | input | 1 | Serial bank data bit |
| ser_shift | input | 1 | Shift strobe for the shadow register |
| bank_latch | input | 1 | Copies the shadow register into the active bank |
| flash_addr | output | 21 | Flash byte address |
| flash_ce_n | output | 1 | Flash chip enable, active low |

## Verification
The hardest case to reach from the ports is a shift and a latch in the same cycle, where the old shadow must move while the new bit enters. The stimulus first builds a known shadow with an overlong load, then strobes both in one clock and reads the two results back through separate latches. Between latches, the window is probed at both halves and at the vector addresses. A long random phase mixes shifts, latches, addresses and a mid-run reset, and a behavioural model is checked against the design on every cycle.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;
    localparam int BANK_BITS  = 7;
    localparam int OFFS_BITS  = 14;
    localparam int CPU_ABITS  = 16;
    localparam int FLASH_ABITS = BANK_BITS + OFFS_BITS;

    typedef enum logic [1:0] {
        SER_IDLE  = 2'b00,
        SER_SHIFT = 2'b01,
        SER_LATCH = 2'b10,
        SER_BOTH  = 2'b11
    } ser_op_e;

    function automatic ser_op_e decode_ser(input logic shift, input logic latch);
        return ser_op_e'({latch, shift});
    endfunction
endpackage

// File: rtl/bank_shift_reg.sv
module bank_shift_reg #(
    parameter int W = cart_map_pkg::BANK_BITS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         ser_bit,
    output logic [W-1:0] shadow
);
    always_ff @(posedge clk) begin
        if (rst)
            shadow <= '0;
        else if (shift_en)
            shadow <= {shadow[W-2:0], ser_bit};
    end

    a_r5_shadow_hold: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(shadow));
endmodule

// File: rtl/bank_active_reg.sv
module bank_active_reg #(
    parameter int W = cart_map_pkg::BANK_BITS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         latch,
    input  logic [W-1:0] shadow_in,
    output logic [W-1:0] bank
);
    always_ff @(posedge clk) begin
        if (rst)
            bank <= '0;
        else if (latch)
            bank <= shadow_in;
    end

    a_r6_latch_copy: assert property (@(posedge clk) disable iff (rst)
        latch |=> bank == $past(shadow_in));
    a_r5_bank_hold: assert property (@(posedge clk) disable iff (rst)
        !latch |=> $stable(bank));
endmodule

// File: rtl/addr_xlate.sv
module addr_xlate #(
    parameter int BANK_W = cart_map_pkg::BANK_BITS,
    parameter int OFFS_W = cart_map_pkg::OFFS_BITS,
    parameter int CPU_W  = cart_map_pkg::CPU_ABITS,
    localparam int FL_W  = BANK_W + OFFS_W
) (
    input  logic [CPU_W-1:0]  cpu_addr,
    input  logic [BANK_W-1:0] bank,
    output logic [FL_W-1:0]   flash_addr,
    output logic              flash_ce_n
);
    logic              upper_half;
    logic [BANK_W-1:0] hi_bits;

    assign upper_half = cpu_addr[OFFS_W];

    always_comb begin
        if (upper_half)
            hi_bits = '1;
        else
            hi_bits = bank;
    end

    assign flash_addr = {hi_bits, cpu_addr[OFFS_W-1:0]};
    assign flash_ce_n = ~cpu_addr[CPU_W-1];
endmodule

// File: rtl/cart_mapper.sv
module cart_mapper #(
    parameter int BANK_W = cart_map_pkg::BANK_BITS,
    parameter int OFFS_W = cart_map_pkg::OFFS_BITS,
    parameter int CPU_W  = cart_map_pkg::CPU_ABITS,
    localparam int FL_W  = BANK_W + OFFS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CPU_W-1:0] cpu_addr,
    input  logic             ser_bit,
    input  logic             ser_shift,
    input  logic             bank_latch,
    output logic [FL_W-1:0]  flash_addr,
    output logic             flash_ce_n
);
    import cart_map_pkg::*;

    ser_op_e           op;
    logic              do_shift;
    logic              do_latch;
    logic [BANK_W-1:0] shadow_q;
    logic [BANK_W-1:0] bank_q;

    assign op       = decode_ser(ser_shift, bank_latch);
    assign do_shift = (op == SER_SHIFT) || (op == SER_BOTH);
    assign do_latch = (op == SER_LATCH) || (op == SER_BOTH);

    bank_shift_reg #(.W(BANK_W)) u_shift (
        .clk(clk), .rst(rst), .shift_en(do_shift),
        .ser_bit(ser_bit), .shadow(shadow_q)
    );

    bank_active_reg #(.W(BANK_W)) u_active (
        .clk(clk), .rst(rst), .latch(do_latch),
        .shadow_in(shadow_q), .bank(bank_q)
    );

    addr_xlate #(.BANK_W(BANK_W), .OFFS_W(OFFS_W), .CPU_W(CPU_W)) u_xlate (
        .cpu_addr(cpu_addr), .bank(bank_q),
        .flash_addr(flash_addr), .flash_ce_n(flash_ce_n)
    );

    a_r2_switch_window: assert property (@(posedge clk) disable iff (rst)
        !cpu_addr[OFFS_W] |-> (flash_addr[FL_W-1:OFFS_W] == bank_q) &&
                              (flash_addr[OFFS_W-1:0] == cpu_addr[OFFS_W-1:0]));
    a_r3_fixed_window: assert property (@(posedge clk) disable iff (rst)
        cpu_addr[OFFS_W] |-> (&flash_addr[FL_W-1:OFFS_W]));
    a_r9_both_ops: assert property (@(posedge clk) disable iff (rst)
        (ser_shift && bank_latch) |=> (bank_q == $past(shadow_q)) &&
                                      (shadow_q[0] == $past(ser_bit)));
    a_r1_chip_enable: assert property (@(posedge clk) disable iff (rst)
        cpu_addr[CPU_W-1] |-> !flash_ce_n);
endmodule

// File: tb/cart_mapper_test.sv
`timescale 1ns/1ps
module cart_mapper_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cpu_addr;
    logic        ser_bit;
    logic        ser_shift;
    logic        bank_latch;
    logic [20:0] flash_addr;
    logic        flash_ce_n;

    int checks = 0;
    int errors = 0;
    int m_shadow = 0;
    int m_bank = 0;

    always #10 clk = ~clk;

    cart_mapper uut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .ser_bit(ser_bit),
        .ser_shift(ser_shift), .bank_latch(bank_latch),
        .flash_addr(flash_addr), .flash_ce_n(flash_ce_n)
    );

    task automatic check_val(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Compare outputs against the model for the address currently driven
    task automatic model_compare();
        int exp_hi;
        exp_hi = cpu_addr[14] ? 32'h7F : m_bank;
        check_val("R1 chip enable", int'(flash_ce_n), cpu_addr[15] ? 0 : 1);
        check_val(cpu_addr[14] ? "R3 fixed window" : "R2 switch window",
                  int'(flash_addr), (exp_hi << 14) | int'(cpu_addr[13:0]));
    endtask

    task automatic step(input logic r, input logic [15:0] a, input logic sh,
                        input logic d, input logic la);
        @(negedge clk);
        rst = r; cpu_addr = a; ser_shift = sh; ser_bit = d; bank_latch = la;
        #1;
        if (!r) model_compare();
        @(posedge clk);
        if (r) begin
            m_shadow = 0; m_bank = 0;
        end else begin
            if (la) m_bank = m_shadow;
            if (sh) m_shadow = ((m_shadow << 1) | int'(d)) & 32'h7F;
        end
    endtask

    task automatic probe(input logic [15:0] a, input string tag, input int exp);
        @(negedge clk);
        rst = 1'b0; cpu_addr = a; ser_shift = 1'b0; bank_latch = 1'b0; ser_bit = 1'b0;
        #1;
        check_val(tag, int'(flash_addr), exp);
        @(posedge clk);
    endtask

    task automatic shift_bits(input int val, input int n);
        for (int i = n - 1; i >= 0; i--)
            step(1'b0, 16'h8000, 1'b1, val[i], 1'b0);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; cpu_addr = 16'h0; ser_bit = 1'b0; ser_shift = 1'b0; bank_latch = 1'b0;
        step(1'b1, 16'h0000, 1'b0, 1'b0, 1'b0);
        step(1'b1, 16'h0000, 1'b0, 1'b0, 1'b0);

        // R7: after reset, bank 0
        probe(16'h8123, "R7 reset bank", 32'h000123);
        // R1: outside window the chip enable stays high
        step(1'b0, 16'h1234, 1'b0, 1'b0, 1'b0);
        check_val("R1 outside window", int'(flash_ce_n), 1);
        // R7: latch straight after reset gives bank 0 (shadow was cleared)
        step(1'b0, 16'h8000, 1'b0, 1'b0, 1'b1);
        probe(16'h8456, "R7 reset shadow", 32'h000456);

        // R4/R5: shift 0x59 MSB first, no latch yet
        shift_bits(32'h59, 7);
        probe(16'h8000, "R5 no latch no change", 32'h000000);
        step(1'b0, 16'hC000, 1'b0, 1'b0, 1'b1);
        // R6/R4: new mapping right after the latch edge
        probe(16'h8ABC, "R4 msb first bank 0x59", 32'h164ABC);
        probe(16'hFFFA, "R3 vector low", 32'h1FFFFA);
        probe(16'hFFFF, "R3 vector high", 32'h1FFFFF);

        // R8: nine bits, only last seven kept -> 0000011
        shift_bits(32'h183, 9);
        step(1'b0, 16'h8000, 1'b0, 1'b0, 1'b1);
        probe(16'hBFFF, "R8 overlong load", 32'h00FFFF);
        // R9: shift and latch together: bank takes 3, shadow becomes 7
        step(1'b0, 16'h8000, 1'b1, 1'b1, 1'b1);
        probe(16'h8001, "R9 latch old shadow", 32'h00C001);
        step(1'b0, 16'h8000, 1'b0, 1'b0, 1'b1);
        probe(16'h8001, "R9 shift still applied", 32'h01C001);
        probe(16'hFFFC, "R3 vector after switch", 32'h1FFFFC);

        // Random mix with the model compared every cycle, including a mid-run reset
        for (int k = 0; k < 600; k++) begin
            logic [15:0] a;
            a = 16'($urandom);
            step((k == 300), a, 1'($urandom), 1'($urandom), ($urandom % 5) == 0);
        end
        probe(16'h8010, "R6 final model bank",
              (m_bank << 14) | 32'h10);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule